// File: doc/BRIEF.md
# Dual-Converter Background Calibration Engine

This block sits behind two half-size successive approximation converters that sample the same analog input. On every conversion it receives both raw bit vectors. It turns each one into a corrected value by adding up the bit-weight estimates that belong to that converter. The final code is the rounded average of the two corrected values. The gap between the two values is the only error signal. It is fed back to both weight tables through a least-mean-squares (LMS) update that pushes the gap toward zero.

No reference signal or test mode is needed. The adaptation runs in the background, and a code leaves the block for every conversion while the weights move. A freeze control holds both tables still while conversion goes on. The step size is a power-of-two right shift chosen at run time. Weights are signed fixed point with FRAC fractional bits below one output LSB and GUARD headroom bits above full scale. The raw per-sample difference is also brought out with the code, so the convergence of the loop can be watched.

Top module: `split_sar_cal`

## Requirements
- R1: After reset, out_valid, out_code and out_diff are 0. Weight i of both tables holds the binary value 2^i LSB, so the top weight is half of full scale.
- R2: A corrected value is the sum, over every bit position set in that converter's raw vector, of that converter's own weight for the position. With nominal weights and freeze high, equal raw vectors give an out_code equal to the raw vector.
- R3: out_code is the average of the two corrected values, rounded to an integer LSB with halves rounded upward: floor((A + B + 2^FRAC) / 2^(FRAC+1)) in fixed-point units.
- R4: out_code saturates to 0 when the rounded average is negative and to 2^16-1 when it is larger than that.
- R5: out_diff is corrected A minus corrected B, signed, in units of 2^-FRAC LSB (FRAC = 8 by default).
- R6: On every valid sample with freeze low, step = out_diff arithmetically shifted right by mu_shift (rounding toward minus infinity). Each A weight whose A bit is 1 decreases by step, and each B weight whose B bit is 1 increases by step. All other weights are unchanged, and a zero difference changes nothing.
- R7: A sample's update is applied only after that sample's output has been formed. A sample entering on the very next clock still uses the weights from before that update.
- R8: While freeze is high no weight changes, and valid codes and differences are still produced for every sample.
- R9: out_valid rises exactly two clocks after in_valid, once per accepted sample. One sample per clock is accepted, and out_valid is never high without a sample two clocks earlier.
- R10: Two converters with opposite weight mismatches (several LSB on the top five bits) are driven with random inputs and mu_shift = 6. The mean absolute out_diff falls below 1 LSB well within 200,000 samples. The same holds for a constant dc input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw sample pair present this cycle |
| raw_a | input | NBITS | Bit decisions of converter A |
| raw_b | input | NBITS | Bit decisions of converter B |
| freeze | input | 1 | High: hold both weight tables |
| mu_shift | input | SHW | LMS step as a right shift of the difference |
| out_valid | output | 1 | Output code present this cycle |
| out_code | output | OUT_W | Rounded, saturated average code |
| out_diff | output | OUT_W+FRAC+GUARD+clog2(NBITS)+1 | Corrected A minus corrected B, FRAC fractional bits |

## Verification
The bench builds the block with its defaults: 16 raw bits, a 16-bit code, 8 fractional bits and 4 guard bits. With 8 fractional bits, step sizes as small as 1/256 LSB can be seen through out_diff, so the round-toward-minus-infinity step and the one-sample update delay can be checked exactly. The guard bits let mu_shift = 0 and 2 push weights far negative and far above full scale without wrapping, which brings both saturation limits of the code within reach. The 16-bit width keeps a full behavioural two-converter convergence run, random and dc, far below the cycle budget.

// File: rtl/split_sar_cal.sv
module split_sar_cal #(
  parameter int NBITS = 16,
  parameter int OUT_W = 16,
  parameter int FRAC  = 8,
  parameter int GUARD = 4,
  parameter int SHW   = 5
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          in_valid,
  input  logic [NBITS-1:0]                              raw_a,
  input  logic [NBITS-1:0]                              raw_b,
  input  logic                                          freeze,
  input  logic [SHW-1:0]                                mu_shift,
  output logic                                          out_valid,
  output logic [OUT_W-1:0]                              out_code,
  output logic signed [OUT_W+FRAC+GUARD+$clog2(NBITS):0] out_diff
);
  localparam int WW  = OUT_W + FRAC + GUARD;
  localparam int SW  = WW + $clog2(NBITS);
  localparam int DW  = SW + 1;
  localparam int LOW = FRAC + OUT_W - NBITS;
  localparam logic signed [DW-1:0] MAXQ = DW'((64'd1 << OUT_W) - 64'd1);
  localparam logic signed [DW-1:0] HALF = DW'(64'd1 << FRAC);

  logic [NBITS-1:0][WW-1:0] wa, wb;
  logic signed [SW-1:0] sa, sb, s1_sa, s1_sb;
  logic [NBITS-1:0]     s1_ra, s1_rb;
  logic                 s1_v;
  logic signed [DW-1:0] diff, tot, q, step_full;
  logic signed [WW-1:0] step;

  always_comb begin
    sa = '0;
    sb = '0;
    for (int i = 0; i < NBITS; i++) begin
      if (raw_a[i]) sa = sa + {{(SW-WW){wa[i][WW-1]}}, wa[i]};
      if (raw_b[i]) sb = sb + {{(SW-WW){wb[i][WW-1]}}, wb[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_sa <= '0;
      s1_sb <= '0;
      s1_ra <= '0;
      s1_rb <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_sa <= sa;
        s1_sb <= sb;
        s1_ra <= raw_a;
        s1_rb <= raw_b;
      end
    end
  end

  assign diff      = {s1_sa[SW-1], s1_sa} - {s1_sb[SW-1], s1_sb};
  assign tot       = {s1_sa[SW-1], s1_sa} + {s1_sb[SW-1], s1_sb};
  assign q         = (tot + HALF) >>> (FRAC + 1);
  assign step_full = diff >>> mu_shift;
  assign step      = step_full[WW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_diff  <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        out_diff <= diff;
        if (q[DW-1])      out_code <= '0;
        else if (q > MAXQ) out_code <= '1;
        else              out_code <= q[OUT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBITS; i++) begin
        wa[i] <= WW'(1) << (LOW + i);
        wb[i] <= WW'(1) << (LOW + i);
      end
    end else if (s1_v && !freeze) begin
      for (int i = 0; i < NBITS; i++) begin
        if (s1_ra[i]) wa[i] <= wa[i] - step;
        if (s1_rb[i]) wb[i] <= wb[i] + step;
      end
    end
  end

  // R9: fixed two-clock latency, no output without a sample
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_v));
  // R8: frozen tables do not move
  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(wa) && $stable(wb)));
  // R6: no sample or zero difference leaves the tables untouched
  a_r6_zero_diff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_v || (s1_sa == s1_sb)) |=> ($stable(wa) && $stable(wb)));
endmodule

// File: tb/split_sar_cal_bench.sv
`timescale 1ns/1ps
module split_sar_cal_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] raw_a = '0, raw_b = '0;
  logic freeze = 1'b1;
  logic [4:0] mu_shift = 5'd6;
  logic out_valid;
  logic [15:0] out_code;
  logic signed [32:0] out_diff;

  split_sar_cal u_split_sar_cal (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raw_a(raw_a), .raw_b(raw_b),
    .freeze(freeze), .mu_shift(mu_shift), .out_valid(out_valid),
    .out_code(out_code), .out_diff(out_diff));

  always #2 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 1'b0;
  longint mA[16], mB[16], wtA[16], wtB[16];

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint corr(logic [15:0] r, bit isA);
    longint s = 0;
    for (int i = 0; i < 16; i++) if (r[i]) s += isA ? mA[i] : mB[i];
    return s;
  endfunction

  function automatic longint round_avg(longint a, longint b);
    return (a + b + 256) >>> 9;
  endfunction

  function automatic longint sat16(longint v);
    return v < 0 ? 0 : (v > 65535 ? 65535 : v);
  endfunction

  task automatic model_update(logic [15:0] ra, logic [15:0] rb, logic [4:0] sh);
    longint st;
    st = (corr(ra, 1'b1) - corr(rb, 1'b0)) >>> sh;
    for (int i = 0; i < 16; i++) begin
      if (ra[i]) mA[i] -= st;
      if (rb[i]) mB[i] += st;
    end
  endtask

  function automatic logic [15:0] sar(longint x, bit isA);
    longint r;
    logic [15:0] b;
    r = x;
    b = '0;
    for (int i = 15; i >= 0; i--) begin
      longint w;
      w = isA ? wtA[i] : wtB[i];
      if (r >= w) begin
        b[i] = 1'b1;
        r -= w;
      end
    end
    return b;
  endfunction

  task automatic do_reset();
    in_valid = 1'b0;
    freeze = 1'b1;
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      mA[i] = longint'(1) << (i + 8);
      mB[i] = longint'(1) << (i + 8);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_one(logic [15:0] ra, logic [15:0] rb, bit frz, logic [4:0] sh,
                          output longint code, output longint dif, output bit vld);
    @(negedge clk);
    raw_a = ra; raw_b = rb; freeze = frz; mu_shift = sh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    vld = out_valid; code = out_code; dif = out_diff;
    @(negedge clk);
    freeze = 1'b1;
    if (!frz) model_update(ra, rb, sh);
  endtask

  task automatic expect_pair(logic [15:0] ra, logic [15:0] rb, bit frz, logic [4:0] sh, string req);
    longint c, d, ea, eb;
    bit v;
    ea = corr(ra, 1'b1);
    eb = corr(rb, 1'b0);
    send_one(ra, rb, frz, sh, c, d, v);
    chk(v, req, v, 1);
    chk(c == sat16(round_avg(ea, eb)), req, c, sat16(round_avg(ea, eb)));
    chk(d == ea - eb, req, d, ea - eb);
  endtask

  task automatic test_reset();
    do_reset();
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(out_code == 16'd0, "R1 out_code", out_code, 0);
    chk(out_diff == 33'sd0, "R1 out_diff", out_diff, 0);
  endtask

  task automatic test_nominal();
    logic [15:0] pats[5] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h5555, 16'h1234};
    longint c, d;
    bit v;
    do_reset();
    foreach (pats[k]) begin
      send_one(pats[k], pats[k], 1'b1, 5'd6, c, d, v);
      chk(c == pats[k], "R1/R2 nominal code", c, pats[k]);
      chk(d == 0, "R2/R5 equal diff", d, 0);
    end
    send_one(16'h00F0, 16'h0F00, 1'b1, 5'd6, c, d, v);
    chk(c == 2040, "R2 mixed code", c, 2040);
    chk(d == -3600 * 256, "R5 mixed diff", d, -3600 * 256);
  endtask

  task automatic test_round();
    longint c, d;
    bit v;
    do_reset();
    send_one(16'd2, 16'd1, 1'b1, 5'd6, c, d, v); chk(c == 2, "R3 1.5 up", c, 2);
    send_one(16'd0, 16'd1, 1'b1, 5'd6, c, d, v); chk(c == 1, "R3 0.5 up", c, 1);
    send_one(16'd1, 16'd1, 1'b1, 5'd6, c, d, v); chk(c == 1, "R3 exact", c, 1);
    send_one(16'd3, 16'd0, 1'b1, 5'd6, c, d, v); chk(c == 2, "R3 1.5 up b", c, 2);
    send_one(16'hFFFF, 16'h0000, 1'b1, 5'd6, c, d, v); chk(c == 32768, "R3 half code", c, 32768);
  endtask

  task automatic test_latency();
    do_reset();
    @(negedge clk);
    raw_a = 16'h0100; raw_b = 16'h0100; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R9 not after one clock", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid after two clocks", out_valid, 1);
    chk(out_code == 16'h0100, "R9 code", out_code, 256);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 single pulse", out_valid, 0);
  endtask

  task automatic test_update();
    do_reset();
    expect_pair(16'd1, 16'd0, 1'b0, 5'd4, "R6 first");
    expect_pair(16'd1, 16'd0, 1'b1, 5'd4, "R6 A decreased");
    chk(mA[0] == 240, "R6 model A0", mA[0], 240);
    expect_pair(16'd0, 16'd1, 1'b0, 5'd4, "R6 B sample");
    expect_pair(16'd0, 16'd1, 1'b1, 5'd4, "R6 B increased");
    expect_pair(16'h0003, 16'h0006, 1'b0, 5'd1, "R6 multi");
    expect_pair(16'h0007, 16'h0007, 1'b1, 5'd1, "R6 multi after");
    expect_pair(16'h0005, 16'h0005, 1'b0, 5'd3, "R6 odd floor");
    expect_pair(16'h0005, 16'h0005, 1'b1, 5'd3, "R6 odd floor after");
  endtask

  task automatic test_delay();
    longint c, d;
    bit v;
    do_reset();
    @(negedge clk);
    raw_a = 16'd1; raw_b = 16'd0; freeze = 1'b0; mu_shift = 5'd4; in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_diff == 256, "R7 first diff", out_diff, 256);
    @(negedge clk);
    chk(out_valid && out_diff == 256, "R7 back-to-back uses old weights", out_diff, 256);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 no extra output", out_valid, 0);
    send_one(16'd1, 16'd0, 1'b1, 5'd4, c, d, v);
    chk(d == 224, "R7 both updates applied", d, 224);
  endtask

  task automatic test_freeze();
    longint c, d;
    bit v;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      send_one(16'hFFFF, 16'h0000, 1'b1, 5'd0, c, d, v);
      chk(v && c == 32768, "R8 output while frozen", c, 32768);
      chk(d == 65535 * 256, "R8 weights held", d, 65535 * 256);
    end
    expect_pair(16'h00FF, 16'h0000, 1'b0, 5'd2, "R8 released");
    expect_pair(16'h00FF, 16'h0000, 1'b1, 5'd2, "R8 moved after release");
  endtask

  task automatic test_sat();
    longint ua;
    do_reset();
    expect_pair(16'hFFFF, 16'h0000, 1'b0, 5'd0, "R4 setup low");
    ua = round_avg(corr(16'hFFFF, 1'b1), 0);
    chk(ua < 0, "R4 low case reached", ua, -1);
    expect_pair(16'hFFFF, 16'h0000, 1'b1, 5'd0, "R4 clamp low");
    chk(out_code == 0, "R4 code zero", out_code, 0);
    expect_pair(16'hFFFF, 16'h0001, 1'b0, 5'd2, "R4 setup high");
    ua = round_avg(corr(16'hFFFF, 1'b1), 0);
    chk(ua > 65535, "R4 high case reached", ua, 65536);
    expect_pair(16'hFFFF, 16'h0000, 1'b1, 5'd0, "R4 clamp high");
    chk(out_code == 16'hFFFF, "R4 code full", out_code, 65535);
  endtask

  task automatic run_stream(bit dc, longint xdc, int n, int win, bit frz, output longint mean_x1k);
    longint acc, x, dv;
    int got;
    acc = 0;
    got = 0;
    for (int k = 0; k < n + 2; k++) begin
      @(negedge clk);
      if (out_valid) begin
        got++;
        dv = out_diff;
        if (got > n - win) acc += (dv < 0) ? -dv : dv;
      end
      if (k < n) begin
        x = dc ? xdc : (longint'(2048) << 8) + longint'($urandom_range(0, 61000 * 256));
        raw_a = sar(x, 1'b1);
        raw_b = sar(x, 1'b0);
        freeze = frz;
        mu_shift = 5'd6;
        in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    mean_x1k = (acc * 1000) / (longint'(win) * 256);
  endtask

  task automatic test_converge();
    longint m;
    longint e[5] = '{1024, -768, 640, -512, 384};
    for (int i = 0; i < 16; i++) begin
      wtA[i] = longint'(1) << (i + 8);
      wtB[i] = longint'(1) << (i + 8);
    end
    for (int k = 0; k < 5; k++) begin
      wtA[15 - k] += e[k];
      wtB[15 - k] -= e[k];
    end
    do_reset();
    run_stream(1'b0, 0, 2000, 2000, 1'b1, m);
    chk(m > 1000, "R10 mismatch visible before adaptation (x1000 LSB)", m, 1001);
    run_stream(1'b0, 0, 30000, 4000, 1'b0, m);
    chk(m < 1000, "R10 random mean abs diff (x1000 LSB)", m, 999);
    do_reset();
    run_stream(1'b1, longint'(45000) * 256 + 77, 1, 1, 1'b1, m);
    chk(m > 1000, "R10 dc mismatch visible (x1000 LSB)", m, 1001);
    run_stream(1'b1, longint'(45000) * 256 + 77, 3000, 1000, 1'b0, m);
    chk(m < 1000, "R10 dc mean abs diff (x1000 LSB)", m, 999);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_nominal();
    test_round();
    test_latency();
    test_update();
    test_delay();
    test_freeze();
    test_sat();
    test_converge();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule